// File: doc/BRIEF.md
# Accumulator and Extension-Bit Execution Unit

This block holds a 16-bit accumulator and a single extension bit that sits above it, and carries out every operation that writes them. It serves two kinds of operation. The first is a register operation, selected by a 12-bit one-hot field, that clears, inverts, rotates or increments the accumulator, tests a condition, or asks the machine to stop. The second is an operation on a memory operand (bitwise AND, add with carry, load) or on an input character.

Each operation arrives as a one-cycle strobe. The accumulator and extension bit update at the next clock edge. Condition tests and stop requests leave as one-cycle pulses that appear in the same cycle as that update. The sequencer that feeds the strobes samples them there.

Top module: `acc_e_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `acc_q`, `ext_q`, `skip_p` and `halt_p` are all 0.
- R2: With `rr_go` high, field value 0x800 clears the accumulator, 0x400 clears the extension bit, 0x200 inverts every accumulator bit, and 0x100 inverts the extension bit. The result is visible after the next rising edge.
- R3: Field value 0x080 rotates the 17-bit pair right: the extension bit enters accumulator bit 15 and accumulator bit 0 enters the extension bit.
- R4: Field value 0x040 rotates the 17-bit pair left: the extension bit enters accumulator bit 0 and accumulator bit 15 enters the extension bit.
- R5: Field value 0x020 adds one to the accumulator. 0xFFFF wraps to 0x0000 and the extension bit is unchanged.
- R6: Field values 0x010, 0x008, 0x004 and 0x002 raise `skip_p` for exactly one cycle, after the next edge, when, respectively, accumulator bit 15 is 0, accumulator bit 15 is 1, the accumulator is zero, or the extension bit is 0. The condition is judged on the values held before that edge.
- R7: Field value 0x001 raises `halt_p` for exactly one cycle after the next edge and leaves the accumulator and extension bit unchanged.
- R8: A register operation whose field does not have exactly one bit set changes nothing and raises no pulse.
- R9: `and_go` sets the accumulator to its bitwise AND with `dr_in`. The extension bit is unchanged.
- R10: `add_go` sets the accumulator to its sum with `dr_in` and writes the carry out of bit 15 into the extension bit.
- R11: `load_go` copies `dr_in` into the accumulator. The extension bit is unchanged.
- R12: `chr_go` copies `chr_in` into accumulator bits 7..0. Bits 15..8 and the extension bit are unchanged.
- R13: When strobes coincide, `rr_go` wins over the operand strobes, then `load_go`, then `add_go`, then `and_go`, and `chr_go` is taken last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rr_go | input | 1 | Execute the register operation in `rr_field` |
| rr_field | input | 12 | One-hot register-operation select |
| and_go | input | 1 | AND operand into accumulator |
| add_go | input | 1 | Add operand, carry to extension bit |
| load_go | input | 1 | Load operand into accumulator |
| chr_go | input | 1 | Load input character into low byte |
| dr_in | input | 16 | Memory operand |
| chr_in | input | 8 | Input character |
| acc_q | output | 16 | Accumulator |
| ext_q | output | 1 | Extension bit |
| skip_p | output | 1 | One-cycle skip-next-instruction pulse |
| halt_p | output | 1 | One-cycle stop request |

## Verification
The rotations are started from 0x8001 with the extension bit at both values. This shows whether the end bits pass through the extension bit or wrap straight around. Adds are chosen so that one produces a carry and one clears an earlier carry, which separates writing the carry from merely setting it. Each skip test is tried on an accumulator of zero and one of 0x8000, so every condition is seen both true and false. Malformed fields and coinciding strobes check that priority and the one-hot guard leave the held values as required.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam int RR_W = 12;

   typedef enum logic [3:0] {
      OP_NONE, OP_CLA, OP_CLE, OP_CMA, OP_CME, OP_ROR, OP_ROL,
      OP_INC, OP_AND, OP_ADD, OP_LDA, OP_CHR
   } op_t;
endpackage

// File: rtl/acc_rr_decode.sv
module acc_rr_decode
   import acc_pkg::*;
(
   input  logic [RR_W-1:0] field,
   output logic            valid,
   output op_t             op,
   output logic [3:0]      skip_sel,
   output logic            halt
);
   always_comb begin
      valid    = $onehot(field);
      op       = OP_NONE;
      skip_sel = 4'b0000;
      halt     = 1'b0;
      case (field)
         12'h800: op = OP_CLA;
         12'h400: op = OP_CLE;
         12'h200: op = OP_CMA;
         12'h100: op = OP_CME;
         12'h080: op = OP_ROR;
         12'h040: op = OP_ROL;
         12'h020: op = OP_INC;
         12'h010: skip_sel = 4'b1000;
         12'h008: skip_sel = 4'b0100;
         12'h004: skip_sel = 4'b0010;
         12'h002: skip_sel = 4'b0001;
         12'h001: halt = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_skip_eval.sv
module acc_skip_eval #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] acc,
   input  logic              ext,
   input  logic [3:0]        sel,
   output logic              skip
);
   logic [3:0] cond;
   always_comb begin
      cond[3] = ~acc[DATA_W-1];
      cond[2] =  acc[DATA_W-1];
      cond[1] = (acc == '0);
      cond[0] = ~ext;
      skip    = |(sel & cond);
   end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
   import acc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CHAR_W = 8
) (
   input  op_t               op,
   input  logic [DATA_W-1:0] acc,
   input  logic              ext,
   input  logic [DATA_W-1:0] dr,
   input  logic [CHAR_W-1:0] chr,
   output logic [DATA_W-1:0] acc_n,
   output logic              ext_n
);
   logic [DATA_W-1:0] chr_merged;
   logic [DATA_W:0]   sum;

   generate
      if (CHAR_W == DATA_W) begin : g_chr_full
         assign chr_merged = chr;
      end else begin : g_chr_low
         assign chr_merged = {acc[DATA_W-1:CHAR_W], chr};
      end
   endgenerate

   assign sum = {1'b0, acc} + {1'b0, dr};

   always_comb begin
      acc_n = acc;
      ext_n = ext;
      unique case (op)
         OP_CLA:  acc_n = '0;
         OP_CLE:  ext_n = 1'b0;
         OP_CMA:  acc_n = ~acc;
         OP_CME:  ext_n = ~ext;
         OP_ROR:  {acc_n, ext_n} = {ext, acc};
         OP_ROL:  {ext_n, acc_n} = {acc, ext};
         OP_INC:  acc_n = acc + 1'b1;
         OP_AND:  acc_n = acc & dr;
         OP_ADD:  {ext_n, acc_n} = sum;
         OP_LDA:  acc_n = dr;
         OP_CHR:  acc_n = chr_merged;
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_e_unit.sv
module acc_e_unit
   import acc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rr_go,
   input  logic [RR_W-1:0]   rr_field,
   input  logic              and_go,
   input  logic              add_go,
   input  logic              load_go,
   input  logic              chr_go,
   input  logic [DATA_W-1:0] dr_in,
   input  logic [CHAR_W-1:0] chr_in,
   output logic [DATA_W-1:0] acc_q,
   output logic              ext_q,
   output logic              skip_p,
   output logic              halt_p
);
   generate
      if (CHAR_W > DATA_W || CHAR_W < 1) begin : g_bad_char_w
         $error("acc_e_unit: CHAR_W must lie in 1..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("acc_e_unit: DATA_W must be at least 2");
      end
   endgenerate

   logic              rr_valid, rr_halt, skip_d;
   op_t               rr_op, op_sel;
   logic [3:0]        rr_skip_sel, skip_sel;
   logic [DATA_W-1:0] acc_n;
   logic              ext_n;

   acc_rr_decode u_dec (
      .field(rr_field), .valid(rr_valid), .op(rr_op),
      .skip_sel(rr_skip_sel), .halt(rr_halt)
   );

   always_comb begin
      if (rr_go)        op_sel = rr_valid ? rr_op : OP_NONE;
      else if (load_go) op_sel = OP_LDA;
      else if (add_go)  op_sel = OP_ADD;
      else if (and_go)  op_sel = OP_AND;
      else if (chr_go)  op_sel = OP_CHR;
      else              op_sel = OP_NONE;
   end

   assign skip_sel = (rr_go && rr_valid) ? rr_skip_sel : 4'b0000;

   acc_skip_eval #(.DATA_W(DATA_W)) u_skip (
      .acc(acc_q), .ext(ext_q), .sel(skip_sel), .skip(skip_d)
   );

   acc_datapath #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
      .op(op_sel), .acc(acc_q), .ext(ext_q), .dr(dr_in), .chr(chr_in),
      .acc_n(acc_n), .ext_n(ext_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         ext_q  <= 1'b0;
         skip_p <= 1'b0;
         halt_p <= 1'b0;
      end else begin
         acc_q  <= acc_n;
         ext_q  <= ext_n;
         skip_p <= skip_d;
         halt_p <= rr_go && rr_valid && rr_halt;
      end
   end

   // R2: clear of the accumulator lands on the next edge
   a_r2_clear_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (rr_go && rr_field == 12'h800) |=> (acc_q == '0));

   // R5: increment never touches the extension bit
   a_r5_inc_keeps_ext: assert property (@(posedge clk) disable iff (!rst_n)
      (rr_go && rr_field == 12'h020) |=> (ext_q == $past(ext_q)));

   // R6: a skip pulse only follows a skip-class register operation
   a_r6_skip_source: assert property (@(posedge clk) disable iff (!rst_n)
      skip_p |-> ($past(rr_go) && $past(|rr_field[4:1])));

   // R7: a halt pulse only follows the halt code
   a_r7_halt_source: assert property (@(posedge clk) disable iff (!rst_n)
      halt_p |-> ($past(rr_go) && $past(rr_field) == 12'h001));

   // R8: malformed field changes nothing
   a_r8_bad_field_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (rr_go && !$onehot(rr_field)) |=>
         ($stable(acc_q) && $stable(ext_q) && !skip_p && !halt_p));

   // R12: character input leaves the upper bits alone
   generate
      if (CHAR_W < DATA_W) begin : g_chr_chk
         a_r12_chr_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
            (chr_go && !rr_go && !load_go && !add_go && !and_go) |=>
               (acc_q[DATA_W-1:CHAR_W] == $past(acc_q[DATA_W-1:CHAR_W])));
      end
   endgenerate
endmodule

// File: tb/acc_e_unit_tb_top.sv
module acc_e_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rr_go = 1'b0, and_go = 1'b0, add_go = 1'b0, load_go = 1'b0, chr_go = 1'b0;
   logic [11:0] rr_field = '0;
   logic [15:0] dr_in = '0;
   logic [7:0]  chr_in = '0;
   logic [15:0] acc_q;
   logic        ext_q, skip_p, halt_p;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_e_unit dut_i (
      .clk(clk), .rst_n(rst_n), .rr_go(rr_go), .rr_field(rr_field),
      .and_go(and_go), .add_go(add_go), .load_go(load_go), .chr_go(chr_go),
      .dr_in(dr_in), .chr_in(chr_in), .acc_q(acc_q), .ext_q(ext_q),
      .skip_p(skip_p), .halt_p(halt_p)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // drive one strobe set for one cycle; results are visible at the following negedge
   task automatic drive(input logic rr, input logic [11:0] fld, input logic a, input logic d,
                        input logic l, input logic c, input logic [15:0] dr, input logic [7:0] ch);
      @(negedge clk);
      rr_go = rr; rr_field = fld; and_go = a; add_go = d; load_go = l; chr_go = c;
      dr_in = dr; chr_in = ch;
      @(negedge clk);
      rr_go = 0; rr_field = '0; and_go = 0; add_go = 0; load_go = 0; chr_go = 0;
   endtask

   task automatic rr(input logic [11:0] fld);
      drive(1'b1, fld, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
   endtask

   task automatic load(input logic [15:0] v);
      drive(1'b0, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0, v, 8'h0);
   endtask

   task automatic set_state(input logic [15:0] v, input logic e);
      load(v);
      rr(12'h400);
      if (e) rr(12'h100);
   endtask

   task automatic t_reset();
      chk("R1 acc", acc_q, 16'h0);
      chk("R1 ext", {15'h0, ext_q}, 16'h0);
      chk("R1 skip", {15'h0, skip_p}, 16'h0);
      chk("R1 halt", {15'h0, halt_p}, 16'h0);
   endtask

   task automatic t_clear_comp();
      set_state(16'h1234, 1'b0);
      rr(12'h200); chk("R2 cma", acc_q, 16'hEDCB);
      rr(12'h100); chk("R2 cme", {15'h0, ext_q}, 16'h1);
      rr(12'h400); chk("R2 cle", {15'h0, ext_q}, 16'h0);
      rr(12'h800); chk("R2 cla", acc_q, 16'h0);
   endtask

   task automatic t_rotate();
      set_state(16'h8001, 1'b0);
      rr(12'h080); chk("R3 ror acc", acc_q, 16'h4000); chk("R3 ror ext", {15'h0, ext_q}, 16'h1);
      rr(12'h080); chk("R3 ror2 acc", acc_q, 16'hA000); chk("R3 ror2 ext", {15'h0, ext_q}, 16'h0);
      set_state(16'h8001, 1'b1);
      rr(12'h040); chk("R4 rol acc", acc_q, 16'h0003); chk("R4 rol ext", {15'h0, ext_q}, 16'h1);
      set_state(16'h4000, 1'b1);
      rr(12'h040); chk("R4 rol2 acc", acc_q, 16'h8001); chk("R4 rol2 ext", {15'h0, ext_q}, 16'h0);
   endtask

   task automatic t_inc();
      set_state(16'hFFFF, 1'b1);
      rr(12'h020); chk("R5 wrap", acc_q, 16'h0); chk("R5 ext kept", {15'h0, ext_q}, 16'h1);
      rr(12'h020); chk("R5 step", acc_q, 16'h1);
   endtask

   task automatic t_skip();
      set_state(16'h0000, 1'b0);
      rr(12'h010); chk("R6 pos true", {15'h0, skip_p}, 16'h1);
      @(negedge clk); chk("R6 one cycle", {15'h0, skip_p}, 16'h0);
      rr(12'h008); chk("R6 neg false", {15'h0, skip_p}, 16'h0);
      rr(12'h004); chk("R6 zero true", {15'h0, skip_p}, 16'h1);
      rr(12'h002); chk("R6 ext0 true", {15'h0, skip_p}, 16'h1);
      set_state(16'h8000, 1'b1);
      rr(12'h010); chk("R6 pos false", {15'h0, skip_p}, 16'h0);
      rr(12'h008); chk("R6 neg true", {15'h0, skip_p}, 16'h1);
      rr(12'h004); chk("R6 zero false", {15'h0, skip_p}, 16'h0);
      rr(12'h002); chk("R6 ext0 false", {15'h0, skip_p}, 16'h0);
      chk("R6 acc kept", acc_q, 16'h8000);
   endtask

   task automatic t_halt();
      set_state(16'h5A5A, 1'b1);
      rr(12'h001);
      chk("R7 halt", {15'h0, halt_p}, 16'h1);
      chk("R7 acc kept", acc_q, 16'h5A5A);
      chk("R7 ext kept", {15'h0, ext_q}, 16'h1);
      @(negedge clk); chk("R7 one cycle", {15'h0, halt_p}, 16'h0);
   endtask

   task automatic t_bad_field();
      set_state(16'h1357, 1'b1);
      rr(12'h0C0);
      chk("R8 two bits acc", acc_q, 16'h1357);
      chk("R8 two bits ext", {15'h0, ext_q}, 16'h1);
      rr(12'h014);
      chk("R8 skip pair", {15'h0, skip_p}, 16'h0);
      rr(12'h000);
      chk("R8 empty acc", acc_q, 16'h1357);
      chk("R8 empty halt", {15'h0, halt_p}, 16'h0);
   endtask

   task automatic t_mem();
      set_state(16'hF0F0, 1'b1);
      drive(1'b0, 12'h0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h3C3C, 8'h0);
      chk("R9 and", acc_q, 16'h3030); chk("R9 ext kept", {15'h0, ext_q}, 16'h1);
      set_state(16'h3030, 1'b0);
      drive(1'b0, 12'h0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 8'h0);
      chk("R10 add carry acc", acc_q, 16'h302F); chk("R10 carry set", {15'h0, ext_q}, 16'h1);
      drive(1'b0, 12'h0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0001, 8'h0);
      chk("R10 add acc", acc_q, 16'h3030); chk("R10 carry cleared", {15'h0, ext_q}, 16'h0);
      rr(12'h100);
      load(16'hBEEF);
      chk("R11 load", acc_q, 16'hBEEF); chk("R11 ext kept", {15'h0, ext_q}, 16'h1);
   endtask

   task automatic t_char();
      set_state(16'hABCD, 1'b1);
      drive(1'b0, 12'h0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0, 8'h5A);
      chk("R12 char", acc_q, 16'hAB5A); chk("R12 ext kept", {15'h0, ext_q}, 16'h1);
   endtask

   task automatic t_prio();
      set_state(16'h00FF, 1'b0);
      drive(1'b1, 12'h200, 1'b0, 1'b0, 1'b1, 1'b0, 16'h1111, 8'h0);
      chk("R13 rr over load", acc_q, 16'hFF00);
      drive(1'b0, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h1234, 8'h0);
      chk("R13 load over and", acc_q, 16'h1234);
      drive(1'b0, 12'h0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0001, 8'h77);
      chk("R13 add over char", acc_q, 16'h1235);
      drive(1'b0, 12'h0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0F0F, 8'h0);
      chk("R13 add over and", acc_q, 16'h2144);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clear_comp();
      t_rotate();
      t_inc();
      t_skip();
      t_halt();
      t_bad_field();
      t_mem();
      t_char();
      t_prio();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule